// File: doc/BRIEF.md
# Operand Line Register Router

This block holds the architectural registers of a small 16-bit processor: five general registers (AX, BX, CX, DX, EX), a stack pointer and an instruction pointer. It routes them onto three read lines, called primary, secondary and tertiary, and accepts results from two write lines, called primary and secondary. Each line is steered by a small select code taken from the instruction word. The primary and secondary write lines reuse the primary and secondary read selects. Code zero stands for the instruction's immediate operand. That operand is read-only, so a write aimed at code zero is thrown away. Instructions use this to drop a result they do not need.

The block also keeps four status flags: zero, sign, carry and overflow. When the update enable is set, the zero and sign flags are computed from the primary result value, and the carry and overflow flags are copied from the ALU. Reads are combinational. Writes and flag updates take effect on the rising clock edge. The asynchronous reset clears every register and every flag.

Top module: `oper_line_router`

## Requirements
- R1: After reset, every register (codes 1 to 7) reads 0x0000 and all four flags read 0.
- R2: On the primary and secondary lines, codes 1 to 5 read AX, BX, CX, DX and EX in that order, code 6 reads SP and code 7 reads IP.
- R3: A line whose select is 0 reads the immediate input when the immediate-present flag is 1, and reads 0x0000 when that flag is 0.
- R4: The tertiary select is 2 bits wide. Code 0 reads the immediate (under the rule of R3), and codes 1, 2 and 3 read AX, BX and CX.
- R5: A write line whose enable is 1 stores its result into the register its select names at the rising clock edge. A read in that same cycle returns the value held before the edge.
- R6: A write whose select is 0 changes no register.
- R7: When both write lines are enabled and select the same nonzero code, the primary result is stored.
- R8: When both write lines are enabled and select different nonzero codes, both results are stored.
- R9: While the flag update enable is 0, all four flags keep their values across clock edges.
- R10: When the flag update enable is 1, at the rising edge the zero flag becomes 1 exactly when the primary result is 0x0000, the sign flag takes bit 15 of the primary result, and the carry and overflow flags take the ALU carry and overflow inputs. This happens whatever the primary write enable and select are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes happen on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 3 | Primary select, used for both reading and writing |
| ssel_i | input | 3 | Secondary select, used for both reading and writing |
| tsel_i | input | 2 | Tertiary read select |
| imm_vld_i | input | 1 | The instruction carries an immediate |
| imm_i | input | 16 | Immediate value |
| pres_i | input | 16 | Primary result |
| pwe_i | input | 1 | Primary write enable |
| sres_i | input | 16 | Secondary result |
| swe_i | input | 1 | Secondary write enable |
| flag_upd_i | input | 1 | Flag update enable |
| alu_carry_i | input | 1 | Unsigned carry from the ALU |
| alu_ovf_i | input | 1 | Signed overflow from the ALU |
| pdata_o | output | 16 | Primary line value |
| sdata_o | output | 16 | Secondary line value |
| tdata_o | output | 16 | Tertiary line value |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Sign flag |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench runs every pair of write selects with both enables set, then reads back all seven registers. A design that decoded code zero as a real register would corrupt a register on a discarded write. A design that gave the secondary line priority would keep the wrong value when both lines hit the same register. Every select combination on all three lines is read with the immediate-present flag both set and clear. This catches a design that leaks the immediate when the flag is clear, or that maps the tertiary codes to the wrong registers. Flag cycles sweep zero, sign-boundary and all-ones results against every carry and overflow input. This shows whether the flags drift while updates are disabled, and whether the zero and sign tests are taken from the wrong value.

// File: rtl/oprt_pkg.sv
package oprt_pkg;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 3;
  localparam int TSEL_W = 2;
  localparam int NREG   = (1 << SEL_W) - 1;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
    logic o;
  } flags_t;
endpackage

// File: rtl/oprt_regbank.sv
module oprt_regbank #(
  parameter int DW    = 16,
  parameter int SEL_W = 3,
  localparam int NREG = (1 << SEL_W) - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SEL_W-1:0]        psel_i,
  input  logic [SEL_W-1:0]        ssel_i,
  input  logic [DW-1:0]           pres_i,
  input  logic                    pwe_i,
  input  logic [DW-1:0]           sres_i,
  input  logic                    swe_i,
  output logic [NREG:1][DW-1:0]   regs_o
);
  // code 0 has no storage: writes to it fall through
  for (genvar k = 1; k <= NREG; k++) begin : g_reg
    logic p_hit, s_hit;
    logic [DW-1:0] q;
    assign p_hit = pwe_i && (psel_i == SEL_W'(k));
    assign s_hit = swe_i && (ssel_i == SEL_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (p_hit) q <= pres_i;  // primary has precedence
      else if (s_hit) q <= sres_i;
    end
    assign regs_o[k] = q;

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pwe_i && psel_i == SEL_W'(k)) && !(swe_i && ssel_i == SEL_W'(k)) |=> $stable(regs_o[k]));
    assert_pri_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwe_i && swe_i && psel_i == SEL_W'(k) && ssel_i == SEL_W'(k)) |=> regs_o[k] == $past(pres_i));
    assert_sec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (swe_i && ssel_i == SEL_W'(k) && !(pwe_i && psel_i == SEL_W'(k))) |=> regs_o[k] == $past(sres_i));
  end
endmodule

// File: rtl/oprt_line_mux.sv
module oprt_line_mux #(
  parameter int DW = 16,
  parameter int W  = 3,
  localparam int NSRC = (1 << W) - 1
) (
  input  logic [W-1:0]            sel_i,
  input  logic                    imm_vld_i,
  input  logic [DW-1:0]           imm_i,
  input  logic [NSRC:1][DW-1:0]   regs_i,
  output logic [DW-1:0]           data_o
);
  always_comb begin
    data_o = imm_vld_i ? imm_i : '0;
    for (int i = 1; i <= NSRC; i++)
      if (sel_i == W'(i)) data_o = regs_i[i];
  end
endmodule

// File: rtl/oprt_flag_unit.sv
module oprt_flag_unit
  import oprt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [DW-1:0] res_i,
  input  logic          carry_i,
  input  logic          ovf_i,
  output flags_t        flags_o
);
  flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else if (upd_i) begin
      flags_q.z <= ~|res_i;
      flags_q.s <= res_i[DW-1];
      flags_q.c <= carry_i;
      flags_q.o <= ovf_i;
    end
  end
  assign flags_o = flags_q;

  assert_flag_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_o));
  assert_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_o.z == ($past(res_i) == '0));
  assert_sign_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_o.s == $past(res_i[DW-1]));
  assert_cout_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_o.c == $past(carry_i) && flags_o.o == $past(ovf_i));
endmodule

// File: rtl/oper_line_router.sv
module oper_line_router
  import oprt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  psel_i,
  input  logic [SEL_W-1:0]  ssel_i,
  input  logic [TSEL_W-1:0] tsel_i,
  input  logic              imm_vld_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] pres_i,
  input  logic              pwe_i,
  input  logic [DATA_W-1:0] sres_i,
  input  logic              swe_i,
  input  logic              flag_upd_i,
  input  logic              alu_carry_i,
  input  logic              alu_ovf_i,
  output logic [DATA_W-1:0] pdata_o,
  output logic [DATA_W-1:0] sdata_o,
  output logic [DATA_W-1:0] tdata_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int TSRC = (1 << TSEL_W) - 1;

  logic [NREG:1][DATA_W-1:0] regs;
  flags_t flags;

  oprt_regbank #(.DW(DATA_W), .SEL_W(SEL_W)) u_bank (
    .clk_i, .rst_ni, .psel_i, .ssel_i, .pres_i, .pwe_i, .sres_i, .swe_i,
    .regs_o(regs)
  );

  oprt_line_mux #(.DW(DATA_W), .W(SEL_W)) u_pmux (
    .sel_i(psel_i), .imm_vld_i, .imm_i, .regs_i(regs), .data_o(pdata_o));
  oprt_line_mux #(.DW(DATA_W), .W(SEL_W)) u_smux (
    .sel_i(ssel_i), .imm_vld_i, .imm_i, .regs_i(regs), .data_o(sdata_o));
  oprt_line_mux #(.DW(DATA_W), .W(TSEL_W)) u_tmux (
    .sel_i(tsel_i), .imm_vld_i, .imm_i, .regs_i(regs[TSRC:1]), .data_o(tdata_o));

  oprt_flag_unit #(.DW(DATA_W)) u_flags (
    .clk_i, .rst_ni, .upd_i(flag_upd_i), .res_i(pres_i),
    .carry_i(alu_carry_i), .ovf_i(alu_ovf_i), .flags_o(flags));

  assign zero_o  = flags.z;
  assign neg_o   = flags.s;
  assign carry_o = flags.c;
  assign ovf_o   = flags.o;

  assert_imm_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i == '0) |-> pdata_o == (imm_vld_i ? imm_i : '0));
  assert_imm_tert_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsel_i == '0) |-> tdata_o == (imm_vld_i ? imm_i : '0));
  assert_read_old_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwe_i && psel_i != '0) |=> $past(pdata_o) != pres_i || pdata_o == $past(pres_i));
endmodule

// File: tb/oper_line_router_tb.sv
module oper_line_router_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_ni = 0;
  logic [2:0] psel = 0, ssel = 0;
  logic [1:0] tsel = 0;
  logic imm_vld = 0, pwe = 0, swe = 0, fupd = 0, acy = 0, aov = 0;
  logic [15:0] imm = 0, pres = 0, sres = 0;
  logic [15:0] pdata, sdata, tdata;
  logic zf, sf, cf, of;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] mdl [1:7];
  logic mz = 0, ms = 0, mc = 0, mo = 0;

  always #(CLK_P/2) clk = ~clk;

  oper_line_router u_dut (
    .clk_i(clk), .rst_ni, .psel_i(psel), .ssel_i(ssel), .tsel_i(tsel),
    .imm_vld_i(imm_vld), .imm_i(imm), .pres_i(pres), .pwe_i(pwe),
    .sres_i(sres), .swe_i(swe), .flag_upd_i(fupd), .alu_carry_i(acy),
    .alu_ovf_i(aov), .pdata_o(pdata), .sdata_o(sdata), .tdata_o(tdata),
    .zero_o(zf), .neg_o(sf), .carry_o(cf), .ovf_o(of));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ev(int code);
    if (code == 0) return imm_vld ? imm : 16'h0;
    return mdl[code];
  endfunction

  task automatic chk_flags(string req);
    chk(req, {12'h0, zf, sf, cf, of}, {12'h0, mz, ms, mc, mo});
  endtask

  task automatic read_all_regs(string req);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      psel = 3'(k);
      #1 chk(req, pdata, mdl[k]);
    end
  endtask

  task automatic wr(int p, int s, logic [15:0] pv, logic [15:0] sv, logic pe, logic se);
    @(negedge clk);
    psel = 3'(p); ssel = 3'(s); pres = pv; sres = sv; pwe = pe; swe = se;
    imm_vld = 0;
    #1;
    chk("R5 old-value read", pdata, ev(p));
    chk("R5 old-value read", sdata, ev(s));
    @(posedge clk);
    if (se && s != 0) mdl[s] = sv;
    if (pe && p != 0) mdl[p] = pv;
    #1 pwe = 0; swe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 1; k <= 7; k++) mdl[k] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;

    // R1: reset state
    read_all_regs("R1");
    chk_flags("R1");

    // R5: load each register through the primary line
    for (int k = 1; k <= 7; k++) wr(k, 0, 16'hA500 ^ 16'(k * 16'h0123), 16'h0, 1, 0);
    // R5: secondary-only writes to a few registers
    wr(0, 2, 16'hFFFF, 16'h2B2B, 0, 1);
    wr(0, 6, 16'hFFFF, 16'h6E6E, 0, 1);
    read_all_regs("R5");

    // R2, R3, R4: full select sweep with the immediate flag set and clear
    for (int v = 0; v < 2; v++)
      for (int p = 0; p < 8; p++)
        for (int s = 0; s < 8; s++)
          for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            psel = 3'(p); ssel = 3'(s); tsel = 2'(t);
            imm_vld = v[0]; imm = 16'h5A3C ^ 16'(p * 16'h1111 + t);
            #1;
            chk((p == 0) ? "R3 primary" : "R2 primary", pdata, ev(p));
            chk((s == 0) ? "R3 secondary" : "R2 secondary", sdata, ev(s));
            chk("R4 tertiary", tdata, ev(t));
          end

    // R6, R7, R8: every pair of write selects with both enables set
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 8; s++) begin
        wr(p, s, 16'hC000 | 16'(p << 4) | 16'(s), 16'h3000 | 16'(p << 8) | 16'(s), 1, 1);
        if (p == s && p != 0) read_all_regs("R7");
        else if (p == 0 || s == 0) read_all_regs("R6");
        else read_all_regs("R8");
      end

    // R9, R10: flag sweep
    for (int i = 0; i < 6; i++)
      for (int u = 0; u < 2; u++)
        for (int c = 0; c < 4; c++) begin
          logic [15:0] rv;
          case (i)
            0: rv = 16'h0000;
            1: rv = 16'h8000;
            2: rv = 16'h7FFF;
            3: rv = 16'h0001;
            4: rv = 16'hFFFF;
            default: rv = 16'h4000;
          endcase
          @(negedge clk);
          psel = 3'(i % 2); pwe = 0; pres = rv; fupd = u[0]; acy = c[0]; aov = c[1];
          @(posedge clk);
          if (u != 0) begin
            mz = (rv == 0); ms = rv[15]; mc = c[0]; mo = c[1];
          end
          #1 fupd = 0;
          chk_flags(u != 0 ? "R10" : "R9");
        end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule